// File: doc/BRIEF.md
# Latency-Hiding Thread Issue Scheduler

This block chooses which of a small pool of hardware thread contexts issues an instruction into one processing pipeline. Each context is either ready or waiting on memory. In every cycle the scheduler grants the first ready context at or after the position just past the most recently issued one. The pipeline reports in that same cycle whether the issued instruction references memory, or depends on memory data that has not yet arrived. If it does, that context is parked, and a different context takes the next slot. Memory latency is hidden by switching threads rather than by caches.

A memory-response port returns a thread tag. A response whose tag names a parked context makes that context ready again. A response with any other tag is dropped and raises an error pulse. When every context is parked, the scheduler grants nothing, raises a stall flag and counts the stalled cycle. A parameter sets how many of the built contexts take part. The remaining contexts are never granted.

Top module: `thr_issue_sched`

## Requirements
- R1: In the first cycle after reset is released, every active context is ready, context 0 holds the grant, `stall_o` is 0, `stall_cnt_o` is 0 and `tag_err_o` is 0.
- R2: `grant_o` has at most one bit set. When bit k is set, `grant_idx_o` equals k.
- R3: Among ready contexts, the grant goes to the first one found by searching upward from the index after the last granted context, wrapping from the highest index to 0. With no blocking, contexts are granted in the order 0, 1, 2, … and the order repeats.
- R4: If `mem_ref_i` is 1 in a cycle in which context k is granted, context k is blocked from the next cycle on. A blocked context is never granted.
- R5: A response (`rsp_valid_i` = 1) whose `rsp_tag_i` names a blocked context makes that context ready from the next cycle on, and it raises no error.
- R6: When no context is ready, `grant_o` is all zeros and `stall_o` is 1. In any cycle with a ready context, `stall_o` is 0.
- R7: `stall_cnt_o` increases by one after each stalled cycle, holds its value in cycles without a stall, and saturates at all ones.
- R8: A response whose tag does not name a blocked context changes no context state. One cycle later, `tag_err_o` pulses to 1.
- R9: If the granted context receives a response in the same cycle in which `mem_ref_i` blocks it, the block takes effect and the response counts as unmatched under R8.
- R10: A context whose index is at or above `ACT_CTX` is never granted. A response tagged with such an index is unmatched under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| mem_ref_i | input | 1 | The instruction issued in this cycle references memory or waits on pending memory data |
| rsp_valid_i | input | 1 | A memory response is present this cycle |
| rsp_tag_i | input | IDX_W | Thread tag carried by the memory response |
| grant_o | output | NUM_CTX | One-hot issue grant, zero while stalled |
| grant_idx_o | output | IDX_W | Index of the granted context |
| stall_o | output | 1 | No context is ready this cycle |
| stall_cnt_o | output | CNT_W | Saturating count of stalled cycles |
| tag_err_o | output | 1 | Pulses one cycle after an unmatched response |

## Verification
Two events can fall in the same cycle: the pipeline blocks the granted context, and a memory response arrives that carries that same context's tag. The bench provokes this by raising `mem_ref_i` together with a response for context 0 in the very cycle that context 0 holds the grant. It then blocks the other active contexts. A stall in the following cycle shows that context 0 stayed parked, and an error pulse shows that the response was dropped. A later legitimate response for context 0 must then restore it without any error.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;

  typedef enum logic {
    CTX_READY   = 1'b0,
    CTX_PARKED  = 1'b1
  } ctx_state_e;

endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/thr_ctx_slot.sv
module thr_ctx_slot
  import thr_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blk_set_i,
  input  logic rsp_sel_i,
  output logic ready_o,
  output logic parked_o
);

  ctx_state_e st_q;
  ctx_state_e st_d;
  logic       st_en;

  // a block outranks a response; a granted slot is never parked, so a
  // response aimed at it is unmatched anyway
  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (blk_set_i) begin
      st_d  = CTX_PARKED;
      st_en = 1'b1;
    end else if (rsp_sel_i && (st_q == CTX_PARKED)) begin
      st_d  = CTX_READY;
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CTX_READY;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign ready_o  = (st_q == CTX_READY);
  assign parked_o = (st_q == CTX_PARKED);

endmodule

// File: rtl/thr_rr_pick.sv
module thr_rr_pick #(
  parameter int NUM_CTX = 8,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX-1:0] ready_i,
  input  logic [IDX_W-1:0]   last_i,
  output logic [NUM_CTX-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    int cand;
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int k = 1; k <= NUM_CTX; k++) begin
      cand = (int'(last_i) + k) % NUM_CTX;
      if (!any_o && ready_i[cand]) begin
        any_o         = 1'b1;
        grant_o[cand] = 1'b1;
        idx_o         = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/thr_stall_ctr.sv
module thr_stall_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = stall_i && (cnt_q != {CNT_W{1'b1}});
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/thr_issue_sched.sv
module thr_issue_sched #(
  parameter int NUM_CTX = 8,
  parameter int ACT_CTX = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_ref_i,
  input  logic               rsp_valid_i,
  input  logic [IDX_W-1:0]   rsp_tag_i,
  output logic [NUM_CTX-1:0] grant_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic               stall_o,
  output logic [CNT_W-1:0]   stall_cnt_o,
  output logic               tag_err_o
);

  logic               rst_int_n;
  logic [NUM_CTX-1:0] ready_vec;
  logic [NUM_CTX-1:0] parked_vec;
  logic [NUM_CTX-1:0] tag_dec;
  logic [NUM_CTX-1:0] rsp_sel;
  logic [NUM_CTX-1:0] blk_set;
  logic [NUM_CTX-1:0] pick_grant;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W-1:0]   last_d;
  logic               last_en;
  logic               err_q;
  logic               err_d;

  thr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // response tag decode; indices beyond the pool never match
  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      tag_dec[i] = (rsp_tag_i == IDX_W'(i));
    end
    rsp_sel = tag_dec & {NUM_CTX{rsp_valid_i}};
    blk_set = pick_grant & {NUM_CTX{mem_ref_i}};
  end

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    if (g < ACT_CTX) begin : g_live
      thr_ctx_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .blk_set_i (blk_set[g]),
        .rsp_sel_i (rsp_sel[g]),
        .ready_o   (ready_vec[g]),
        .parked_o  (parked_vec[g])
      );
    end else begin : g_idle
      assign ready_vec[g]  = 1'b0;
      assign parked_vec[g] = 1'b0;
    end
  end

  thr_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
    .ready_i (ready_vec),
    .last_i  (last_q),
    .grant_o (pick_grant),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  always_comb begin
    last_en = pick_any;
    last_d  = pick_idx;
    err_d   = rsp_valid_i && ((rsp_sel & parked_vec) == '0);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      last_q <= IDX_W'(NUM_CTX - 1);
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  thr_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .stall_i (!pick_any),
    .cnt_o   (stall_cnt_o)
  );

  assign grant_o     = pick_grant;
  assign grant_idx_o = pick_idx;
  assign stall_o     = !pick_any;
  assign tag_err_o   = err_q;

endmodule

// File: rtl/thr_sched_chk.sv
module thr_sched_chk #(
  parameter int NUM_CTX = 8,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_int_n,
  input logic               mem_ref_i,
  input logic               rsp_valid_i,
  input logic [IDX_W-1:0]   rsp_tag_i,
  input logic [NUM_CTX-1:0] grant_o,
  input logic               stall_o,
  input logic [CNT_W-1:0]   stall_cnt_o,
  input logic               tag_err_o,
  input logic [NUM_CTX-1:0] parked_vec
);

  logic tag_parked;
  always_comb begin
    tag_parked = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (rsp_tag_i == IDX_W'(i) && parked_vec[i]) tag_parked = 1'b1;
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant_o));

  p_no_parked_grant_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (grant_o & parked_vec) == '0);

  p_block_next_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((grant_o != '0) && mem_ref_i) |=> ((grant_o & $past(grant_o)) == '0));

  p_stall_nogrant_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    stall_o |-> (grant_o == '0));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stall_o && (stall_cnt_o != {CNT_W{1'b1}})) |=> (stall_cnt_o == $past(stall_cnt_o) + CNT_W'(1)));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stall_o |=> $stable(stall_cnt_o));

  p_good_rsp_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid_i && tag_parked) |=> !tag_err_o);

  p_bad_rsp_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid_i && !tag_parked) |=> tag_err_o);

endmodule

bind thr_issue_sched thr_sched_chk #(
  .NUM_CTX (NUM_CTX),
  .CNT_W   (CNT_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .mem_ref_i   (mem_ref_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_tag_i   (rsp_tag_i),
  .grant_o     (grant_o),
  .stall_o     (stall_o),
  .stall_cnt_o (stall_cnt_o),
  .tag_err_o   (tag_err_o),
  .parked_vec  (parked_vec)
);

// File: tb/tb_thr_issue_sched.sv
module tb_thr_issue_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTX    = 4;
  localparam int ACT_CTX    = 3;
  localparam int CNT_W      = 4;
  localparam int IDX_W      = 2;
  localparam int WDOG_LIM   = 20000;

  logic               clk;
  logic               rst_n;
  logic               mem_ref_i;
  logic               rsp_valid_i;
  logic [IDX_W-1:0]   rsp_tag_i;
  logic [NUM_CTX-1:0] grant_o;
  logic [IDX_W-1:0]   grant_idx_o;
  logic               stall_o;
  logic [CNT_W-1:0]   stall_cnt_o;
  logic               tag_err_o;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  thr_issue_sched #(.NUM_CTX(NUM_CTX), .ACT_CTX(ACT_CTX), .CNT_W(CNT_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_ref_i   (mem_ref_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_tag_i   (rsp_tag_i),
    .grant_o     (grant_o),
    .grant_idx_o (grant_idx_o),
    .stall_o     (stall_o),
    .stall_cnt_o (stall_cnt_o),
    .tag_err_o   (tag_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > WDOG_LIM) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WDOG_LIM);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // granted index check: one-hot value and index together
  task automatic chk_grant(input string req, input int idx);
    chk({req, " grant"}, int'(grant_o), 1 << idx);
    chk({req, " idx"}, int'(grant_idx_o), idx);
    chk({req, " stall"}, int'(stall_o), 0);
  endtask

  // present inputs for the current cycle, advance to the next sample point
  task automatic step(input bit m, input bit v, input int tag);
    mem_ref_i   = m;
    rsp_valid_i = v;
    rsp_tag_i   = IDX_W'(tag);
    @(posedge clk);
    @(negedge clk);
    mem_ref_i   = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_tag_i   = '0;
  endtask

  task automatic do_reset();
    mem_ref_i   = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_tag_i   = '0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_grant("R1", 0);
    chk("R1 cnt", int'(stall_cnt_o), 0);
    chk("R1 err", int'(tag_err_o), 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int k = 0; k < 7; k++) begin
      chk_grant("R3 R2 R10 rotation", k % ACT_CTX);
      step(1'b0, 1'b0, 0);
    end
  endtask

  task automatic t_block_wake();
    do_reset();
    chk_grant("R4 c0", 0);
    step(1'b1, 1'b0, 0);
    chk_grant("R4 skip parked 0", 1);
    step(1'b1, 1'b0, 0);
    chk_grant("R4 skip parked 0,1", 2);
    step(1'b0, 1'b0, 0);
    chk_grant("R4 only 2 ready", 2);
    step(1'b0, 1'b1, 0);
    chk_grant("R5 woken 0", 0);
    chk("R5 no err", int'(tag_err_o), 0);
  endtask

  task automatic t_stall();
    do_reset();
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    chk("R6 stall", int'(stall_o), 1);
    chk("R6 no grant", int'(grant_o), 0);
    chk("R7 cnt before", int'(stall_cnt_o), 0);
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 1);
    chk_grant("R5 wake from stall", 1);
    chk("R7 cnt three", int'(stall_cnt_o), 3);
    step(1'b0, 1'b0, 0);
    chk("R7 cnt hold", int'(stall_cnt_o), 3);
  endtask

  task automatic t_saturate();
    do_reset();
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 0);
    chk("R7 saturate", int'(stall_cnt_o), (1 << CNT_W) - 1);
    chk("R6 still stall", int'(stall_o), 1);
  endtask

  task automatic t_bad_tag();
    do_reset();
    step(1'b0, 1'b1, 2);
    chk("R8 err pulse", int'(tag_err_o), 1);
    chk_grant("R8 c1", 1);
    step(1'b0, 1'b1, 3);
    chk("R10 err inactive tag", int'(tag_err_o), 1);
    chk_grant("R8 ctx 2 unaffected", 2);
    step(1'b0, 1'b0, 0);
    chk("R8 err clears", int'(tag_err_o), 0);
    chk_grant("R10 wraps past 3", 0);
  endtask

  task automatic t_collide();
    do_reset();
    step(1'b1, 1'b1, 0);
    chk("R9 err", int'(tag_err_o), 1);
    chk_grant("R9 c1", 1);
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    chk("R9 block won", int'(stall_o), 1);
    step(1'b0, 1'b1, 0);
    chk_grant("R9 later wake", 0);
    chk("R9 later no err", int'(tag_err_o), 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc   = 0;
    done  = 1'b0;
    t_reset_state();
    t_round_robin();
    t_block_wake();
    t_stall();
    t_saturate();
    t_bad_tag();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule